// File: doc/BRIEF.md
# Balanced Partial-Product Summing Array

This combinational block is the addition core of a wide multiplier. It takes eighteen operand rows, each 66 bits wide and already aligned to its weight: the recoded partial products of a multiplication, plus the rows that carry an accumulator addend for a multiply-add or multiply-subtract. It reduces them to one sum vector and one carry vector. A carry-propagate adder then adds these two vectors to give the true total. The caller drives every row it does not need with zero.

The reduction goes through four levels that alternate the cell type. The first level uses full-adder (3:2) cells and turns 18 rows into 12. The second uses 4-2 compressors and turns 12 rows into 6. The third uses 3:2 cells again and turns 6 rows into 4. The last uses one row of 4-2 compressors and turns 4 rows into 2. Every level receives a row count that its cell divides exactly, so no leftover rows travel a longer path.

Inside the 4-2 cell, the lateral carry depends only on three of the four inputs of the cell. Because of this, no carry ripples along the row. Every weight-2 output is moved up one bit before it enters the next level. Anything carried past bit 65 is dropped, so all arithmetic is modulo 2^66.

Top module: `wal_hybrid_tree`

## Requirements
- R1: `total_o` equals the sum of all 18 input rows, modulo 2^66, for any input values.
- R2: `red_sum_o + red_cry_o` equals the sum of all 18 input rows, modulo 2^66.
- R3: The 12 rows after the first 3:2 level sum to the same value, modulo 2^66, as the 18 input rows.
- R4: The 6 rows after the 4-2 level sum to the same value, modulo 2^66, as the 12 rows that feed that level.
- R5: The 4 rows after the second 3:2 level sum to the same value, modulo 2^66, as the 6 rows that feed that level.
- R6: When all rows are zero, `red_sum_o`, `red_cry_o` and `total_o` are all zero.
- R7: Overflow wraps. With all 18 rows set to all ones, `total_o` equals 2^66 - 18.
- R8: Bit 0 of `red_cry_o` is always 0, because every carry is shifted up one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rows_i | input | 18x66 | Aligned operand rows. Unused rows are driven with zero. |
| red_sum_o | output | 66 | Sum vector of the redundant result |
| red_cry_o | output | 66 | Carry vector of the redundant result, already aligned to its weight |
| total_o | output | 66 | Carry-propagated total, modulo 2^66 |

## Verification
The checks inside the block are immediate assertions that compare modular sums between adjacent levels. They assume that every input bit holds a defined 0 or 1. They also assume that the rows stay constant while the tree settles, so that a check never sees half-updated values. The bench therefore drives all eighteen rows together, with defined values, in a single step just after a rising clock edge. It reads the outputs only at the following falling edge. Directed cases cover zero rows, saturated rows and a single non-zero row, and these are mixed with random rows.

// File: rtl/wal_hybrid_tree.sv
module wal_hybrid_tree #(
  parameter int W = 66
) (
  input  logic [17:0][W-1:0] rows_i,
  output logic [W-1:0]       red_sum_o,
  output logic [W-1:0]       red_cry_o,
  output logic [W-1:0]       total_o
);
  localparam int N1 = 12;
  localparam int N2 = 6;
  localparam int N3 = 4;

  function automatic logic [2*W-1:0] fa_row(input logic [W-1:0] a, b, c);
    logic [W-1:0] s, k;
    s = a ^ b ^ c;
    k = (a & b) | (a & c) | (b & c);
    return {k << 1, s};
  endfunction

  function automatic logic [2*W-1:0] c42_row(input logic [W-1:0] a, b, c, d);
    logic [W-1:0] t, lat, cin, s, k;
    t   = a ^ b ^ c;
    lat = (a & b) | (a & c) | (b & c);
    cin = lat << 1;
    s   = t ^ d ^ cin;
    k   = (t & d) | (t & cin) | (d & cin);
    return {k << 1, s};
  endfunction

  logic [N1-1:0][W-1:0] lv1;
  logic [N2-1:0][W-1:0] lv2;
  logic [N3-1:0][W-1:0] lv3;

  for (genvar g = 0; g < N1 / 2; g++) begin : g_lv1
    assign {lv1[2*g+1], lv1[2*g]} = fa_row(rows_i[3*g], rows_i[3*g+1], rows_i[3*g+2]);
  end

  for (genvar g = 0; g < N2 / 2; g++) begin : g_lv2
    assign {lv2[2*g+1], lv2[2*g]} = c42_row(lv1[4*g], lv1[4*g+1], lv1[4*g+2], lv1[4*g+3]);
  end

  for (genvar g = 0; g < N3 / 2; g++) begin : g_lv3
    assign {lv3[2*g+1], lv3[2*g]} = fa_row(lv2[3*g], lv2[3*g+1], lv2[3*g+2]);
  end

  assign {red_cry_o, red_sum_o} = c42_row(lv3[0], lv3[1], lv3[2], lv3[3]);
  assign total_o = red_sum_o + red_cry_o;
endmodule

// File: rtl/wal_hybrid_tree_chk.sv
module wal_hybrid_tree_chk #(
  parameter int W = 66
) (
  input logic [17:0][W-1:0] rows_i,
  input logic [11:0][W-1:0] lv1,
  input logic [5:0][W-1:0]  lv2,
  input logic [3:0][W-1:0]  lv3,
  input logic [W-1:0]       red_sum_o,
  input logic [W-1:0]       red_cry_o,
  input logic [W-1:0]       total_o
);
  logic [W-1:0] in_sum, s1, s2, s3;

  always_comb begin
    in_sum = '0;
    s1 = '0;
    s2 = '0;
    s3 = '0;
    for (int i = 0; i < 18; i++) in_sum = in_sum + rows_i[i];
    for (int i = 0; i < 12; i++) s1 = s1 + lv1[i];
    for (int i = 0; i < 6; i++)  s2 = s2 + lv2[i];
    for (int i = 0; i < 4; i++)  s3 = s3 + lv3[i];
  end

  always_comb begin
    if (!$isunknown(rows_i)) begin
      // R3
      lv1_sum_chk: assert (s1 == in_sum) else $error("level 1 sum mismatch");
      // R4
      lv2_sum_chk: assert (s2 == s1) else $error("level 2 sum mismatch");
      // R5
      lv3_sum_chk: assert (s3 == s2) else $error("level 3 sum mismatch");
      // R2
      redundant_chk: assert (W'(red_sum_o + red_cry_o) == s3) else $error("final pair mismatch");
      // R1
      total_chk: assert (total_o == in_sum) else $error("total mismatch");
    end
  end
endmodule

bind wal_hybrid_tree wal_hybrid_tree_chk #(.W(W)) u_chk (
  .rows_i(rows_i), .lv1(lv1), .lv2(lv2), .lv3(lv3),
  .red_sum_o(red_sum_o), .red_cry_o(red_cry_o), .total_o(total_o)
);

// File: tb/wal_hybrid_tree_test.sv
`timescale 1ns/1ps
module wal_hybrid_tree_test;
  localparam int W = 66;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [17:0][W-1:0] rows;
  logic [W-1:0] rsum, rcry, tot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  wal_hybrid_tree #(.W(W)) uut (
    .rows_i(rows), .red_sum_o(rsum), .red_cry_o(rcry), .total_o(tot)
  );

  function automatic logic [W-1:0] ref_sum(input logic [17:0][W-1:0] r);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < 18; i++) acc = acc + r[i];
    return acc;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0][W-1:0] r);
    logic [W-1:0] e;
    @(posedge clk);
    #1 rows = r;
    @(negedge clk);
    e = ref_sum(r);
    chk("R1 total", tot, e);
    chk("R2 redundant pair", W'(rsum + rcry), e);
    chk("R8 carry bit0", {{(W-1){1'b0}}, rcry[0]}, '0);
  endtask

  function automatic logic [W-1:0] rnd_row();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [17:0][W-1:0] r;
    rows = '0;
    // R6 zero rows
    apply('0);
    chk("R6 sum zero", rsum, '0);
    chk("R6 carry zero", rcry, '0);
    chk("R6 total zero", tot, '0);
    // R7 wrap with saturated rows
    r = '1;
    apply(r);
    chk("R7 wrap", tot, W'(0) - W'(18));
    // single non-zero row in each slot, others zero
    for (int k = 0; k < 18; k++) begin
      r = '0;
      r[k] = rnd_row();
      apply(r);
      chk("R1 single row", tot, r[k]);
    end
    // top-bit rows only, sparse patterns
    r = '0;
    for (int k = 0; k < 18; k++) r[k] = {1'b1, {(W-1){1'b0}}};
    apply(r);
    chk("R7 msb wrap", tot, '0);
    // random full vectors (R3 R4 R5 covered by level assertions)
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 18; k++) r[k] = rnd_row();
      if (n % 4 == 1) for (int k = 14; k < 18; k++) r[k] = '0;
      apply(r);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule